// File: doc/BRIEF.md
# PLL Lock Status Monitor

This block decides whether a disciplined-oscillator phase-locked loop is in lock and drives one flag from that decision, suitable for a front-panel indicator. It takes three things: the digitised control word that steers the oscillator tuning voltage, delivered as strobed samples, and the two raw signals that feed the phase detector. Those are the reference pulse train and the divided-down local oscillator.

Two independent tests must pass before the flag is raised. First, every control-word sample must lie inside a window that excludes the lowest and highest tenth of the code range. Second, both detector inputs must keep showing rising edges. The second test matters because a dead input makes an exclusive-or detector settle at mid-scale, so the control word looks healthy. After both tests pass, the flag still waits for a run of consecutive good samples, which stops it from chattering. Any single fault drops the flag at once.

Top module: `pll_lock_monitor`

## Requirements
- R1: With the full scale FS = 2^CW_W − 1, a sample whose code is below FS/10 (integer division) is out of window. For CW_W = 12 the code 408 is out and 409 is in.
- R2: A sample whose code is above FS − FS/10 is out of window. For CW_W = 12 the code 3686 is in and 3687 is out.
- R3: `out_of_window` takes the verdict of each sample on the clock edge that accepts it (the edge where `cw_valid` is high). It keeps that value until the next sample, however many cycles pass.
- R4: An out-of-window sample clears `locked` on the same edge that accepts the sample, and it restarts the good-sample count from zero.
- R5: `locked` rises on the edge that accepts the QUAL_COUNT-th consecutive good sample and not before. A good sample is one that is in window while neither input is flagged missing. Once high, `locked` stays high until a fault occurs.
- R6: When an input shows no rising edge for more than ACT_LIMIT clock cycles, its missing flag is set. A rising edge clears the flag within SYNC_STAGES + 1 cycles.
- R7: Each input has its own missing flag, `ref_missing` for the reference and `osc_missing` for the oscillator. A dead reference does not set `osc_missing`, and a dead oscillator does not set `ref_missing`.
- R8: While either missing flag is set, `locked` is low on the following edge and stays low, even when every sample is at mid-scale.
- R9: Synchronous active-high `rst` clears `locked`, `out_of_window` and all counters, and sets both missing flags. A level that is already high when reset ends does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_valid | input | 1 | Strobe marking a new control-word sample |
| cw_code | input | CW_W | Control-word sample, unsigned |
| ref_in | input | 1 | Reference pulse input, asynchronous |
| osc_in | input | 1 | Divided oscillator input, asynchronous |
| locked | output | 1 | Loop declared in lock |
| out_of_window | output | 1 | Verdict of the last sample |
| ref_missing | output | 1 | No recent reference edges |
| osc_missing | output | 1 | No recent oscillator edges |

## Verification
The window test is driven with codes on both sides of each limit, at the extremes, and at mid-scale. Off-by-one comparisons show up at 408/409 and 3686/3687. The lock qualifier gets runs of QUAL_COUNT − 1 and QUAL_COUNT good samples, both before and after a single bad sample, which shows whether the count restarts or merely pauses. Each input is silenced alone while mid-scale samples keep arriving. This separates the two missing flags from each other, and it shows that a dead input defeats a window-only decision. A reset applied while the loop is locked shows that the flag falls and that the missing flags start set.

// File: rtl/plm_pkg.sv
package plm_pkg;
   // Full scale of an unsigned code of the given width.
   function automatic int unsigned full_scale(input int unsigned w);
      return (32'd1 << w) - 32'd1;
   endfunction

   // Lowest in-window code: one tenth of full scale.
   function automatic int unsigned low_limit(input int unsigned w);
      return full_scale(w) / 10;
   endfunction

   // Highest in-window code: full scale minus one tenth.
   function automatic int unsigned high_limit(input int unsigned w);
      return full_scale(w) - (full_scale(w) / 10);
   endfunction

   localparam int unsigned NUM_DET = 2;   // detector inputs watched
   localparam int unsigned IDX_REF = 0;
   localparam int unsigned IDX_OSC = 1;
endpackage

// File: rtl/plm_window.sv
module plm_window #(
   parameter int unsigned CW_W = 12
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            valid,
   input  logic [CW_W-1:0] code,
   output logic            sample_bad,
   output logic            oow_q
);
   localparam logic [CW_W-1:0] LO_LIM = CW_W'(plm_pkg::low_limit(CW_W));
   localparam logic [CW_W-1:0] HI_LIM = CW_W'(plm_pkg::high_limit(CW_W));

   assign sample_bad = (code < LO_LIM) || (code > HI_LIM);

   always_ff @(posedge clk) begin
      if (rst)        oow_q <= 1'b0;
      else if (valid) oow_q <= sample_bad;
   end
endmodule

// File: rtl/plm_edge_watch.sv
module plm_edge_watch #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ACT_LIMIT   = 1000
) (
   input  logic clk,
   input  logic rst,
   input  logic sig_in,
   output logic missing
);
   localparam int unsigned CNT_W = $clog2(ACT_LIMIT + 1);
   localparam logic [CNT_W-1:0] LIM = CNT_W'(ACT_LIMIT);

   // pipe[0..SYNC_STAGES-1] synchronise, pipe[SYNC_STAGES] holds the prior value
   logic [SYNC_STAGES:0] pipe;
   logic                 rise;
   logic [CNT_W-1:0]     gap_cnt;

   always_ff @(posedge clk) begin
      if (rst) pipe <= '1;   // a level high at reset release is not an edge
      else     pipe <= {pipe[SYNC_STAGES-1:0], sig_in};
   end

   assign rise = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         gap_cnt <= '0;
         missing <= 1'b1;
      end else if (rise) begin
         gap_cnt <= '0;
         missing <= 1'b0;
      end else if (gap_cnt == LIM) begin
         missing <= 1'b1;
      end else begin
         gap_cnt <= gap_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/plm_qualify.sv
module plm_qualify #(
   parameter int unsigned QUAL_COUNT = 256
) (
   input  logic clk,
   input  logic rst,
   input  logic sample_valid,
   input  logic sample_bad,
   input  logic input_lost,
   output logic locked
);
   localparam int unsigned QW = $clog2(QUAL_COUNT + 1);
   localparam logic [QW-1:0] LAST = QW'(QUAL_COUNT - 1);

   logic [QW-1:0] good_cnt;
   logic          fault;

   assign fault = input_lost || (sample_valid && sample_bad);

   always_ff @(posedge clk) begin
      if (rst || fault) begin
         good_cnt <= '0;
         locked   <= 1'b0;
      end else if (sample_valid && !locked) begin
         if (good_cnt == LAST) locked <= 1'b1;
         else                  good_cnt <= good_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
   parameter int unsigned CW_W        = 12,
   parameter int unsigned QUAL_COUNT  = 256,
   parameter int unsigned ACT_LIMIT   = 1000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            cw_valid,
   input  logic [CW_W-1:0] cw_code,
   input  logic            ref_in,
   input  logic            osc_in,
   output logic            locked,
   output logic            out_of_window,
   output logic            ref_missing,
   output logic            osc_missing
);
   import plm_pkg::*;

   if (CW_W < 4 || CW_W > 24) begin : g_bad_cw
      $error("CW_W must be 4..24");
   end
   if (QUAL_COUNT < 1) begin : g_bad_qual
      $error("QUAL_COUNT must be at least 1");
   end
   if (ACT_LIMIT < 2) begin : g_bad_act
      $error("ACT_LIMIT must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic               sample_bad;
   logic [NUM_DET-1:0] det_in;
   logic [NUM_DET-1:0] det_missing;

   assign det_in[IDX_REF] = ref_in;
   assign det_in[IDX_OSC] = osc_in;

   plm_window #(.CW_W(CW_W)) win_i (
      .clk(clk), .rst(rst), .valid(cw_valid), .code(cw_code),
      .sample_bad(sample_bad), .oow_q(out_of_window)
   );

   for (genvar i = 0; i < NUM_DET; i++) begin : g_watch
      plm_edge_watch #(.SYNC_STAGES(SYNC_STAGES), .ACT_LIMIT(ACT_LIMIT)) watch_i (
         .clk(clk), .rst(rst), .sig_in(det_in[i]), .missing(det_missing[i])
      );
   end

   plm_qualify #(.QUAL_COUNT(QUAL_COUNT)) qual_i (
      .clk(clk), .rst(rst), .sample_valid(cw_valid), .sample_bad(sample_bad),
      .input_lost(|det_missing), .locked(locked)
   );

   assign ref_missing = det_missing[IDX_REF];
   assign osc_missing = det_missing[IDX_OSC];
endmodule

// File: rtl/plm_checker.sv
module plm_checker #(
   parameter int unsigned CW_W = 12
) (
   input logic            clk,
   input logic            rst,
   input logic            cw_valid,
   input logic [CW_W-1:0] cw_code,
   input logic            locked,
   input logic            out_of_window,
   input logic            ref_missing,
   input logic            osc_missing
);
   localparam int unsigned LO = plm_pkg::low_limit(CW_W);
   localparam int unsigned HI = plm_pkg::high_limit(CW_W);

   logic code_outside;
   assign code_outside = (32'(cw_code) < LO) || (32'(cw_code) > HI);

   // R1, R2, R4: an outside sample unlocks and is flagged on the accepting edge
   a_r4_bad_sample_unlocks: assert property (@(posedge clk) disable iff (rst)
      (cw_valid && code_outside) |=> (!locked && out_of_window));

   // R3: without a sample the window flag holds
   a_r3_flag_holds: assert property (@(posedge clk) disable iff (rst)
      !cw_valid |=> $stable(out_of_window));

   // R5: lock only rises on an edge that accepted a sample
   a_r5_rise_on_sample: assert property (@(posedge clk) disable iff (rst)
      $rose(locked) |-> $past(cw_valid));

   // R8: a missing input forbids lock on the next edge
   a_r8_missing_unlocks: assert property (@(posedge clk) disable iff (rst)
      (ref_missing || osc_missing) |=> !locked);

   // R9: reset state
   a_r9_reset_state: assert property (@(posedge clk)
      rst |=> (!locked && !out_of_window && ref_missing && osc_missing));
endmodule

bind pll_lock_monitor plm_checker #(.CW_W(CW_W)) chk_i (
   .clk(clk), .rst(rst), .cw_valid(cw_valid), .cw_code(cw_code),
   .locked(locked), .out_of_window(out_of_window),
   .ref_missing(ref_missing), .osc_missing(osc_missing)
);

// File: tb/pll_lock_monitor_tb_top.sv
module pll_lock_monitor_tb_top;
   localparam int unsigned CW_W  = 12;
   localparam int unsigned QUAL  = 8;
   localparam int unsigned LIMIT = 40;
   localparam int          NVEC  = 8;

   // code, expected out_of_window verdict (R1, R2)
   localparam logic [CW_W-1:0] VEC_CODE [NVEC] =
      '{12'd2048, 12'd0, 12'd408, 12'd409, 12'd3686, 12'd3687, 12'd4095, 12'd1000};
   localparam bit VEC_OOW [NVEC] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cw_valid = 1'b0;
   logic [CW_W-1:0] cw_code = '0;
   logic ref_in = 1'b0, osc_in = 1'b0;
   logic ref_en = 1'b0, osc_en = 1'b0;
   logic locked, out_of_window, ref_missing, osc_missing;
   int   n_chk = 0, n_bad = 0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   pll_lock_monitor #(.CW_W(CW_W), .QUAL_COUNT(QUAL), .ACT_LIMIT(LIMIT), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst(rst), .cw_valid(cw_valid), .cw_code(cw_code),
      .ref_in(ref_in), .osc_in(osc_in), .locked(locked),
      .out_of_window(out_of_window), .ref_missing(ref_missing), .osc_missing(osc_missing)
   );

   // detector inputs toggle every 5 cycles (edge every 10) while enabled
   initial forever begin
      repeat (5) @(negedge clk);
      if (ref_en) ref_in = ~ref_in;
   end
   initial forever begin
      repeat (5) @(negedge clk);
      if (osc_en) osc_in = ~osc_in;
   end

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // one sample; returns just after the accepting edge
   task automatic sample(input logic [CW_W-1:0] c);
      @(negedge clk);
      cw_valid = 1'b1;
      cw_code  = c;
      @(negedge clk);
      cw_valid = 1'b0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      // R9: reset state with inputs quiet
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R9 locked", locked, 1'b0);
      chk("R9 oow", out_of_window, 1'b0);
      chk("R9 ref_missing", ref_missing, 1'b1);
      chk("R9 osc_missing", osc_missing, 1'b1);

      // R8: mid-scale samples with both inputs dead never lock
      for (int i = 0; i < QUAL + 2; i++) sample(12'd2048);
      chk("R8 dead inputs mid-scale", locked, 1'b0);

      // R6: edges clear missing flags
      ref_en = 1'b1;
      osc_en = 1'b1;
      repeat (20) @(negedge clk);
      chk("R6 ref cleared", ref_missing, 1'b0);
      chk("R6 osc cleared", osc_missing, 1'b0);

      // R1, R2, R3, R4: vector table
      for (int v = 0; v < NVEC; v++) begin
         sample(VEC_CODE[v]);
         chk("R1/R2 window verdict", out_of_window, VEC_OOW[v]);
         if (VEC_OOW[v]) chk("R4 bad sample unlock", locked, 1'b0);
      end
      sample(12'd4000);
      repeat (12) @(negedge clk);
      chk("R3 flag held", out_of_window, 1'b1);
      sample(12'd2000);
      chk("R3 flag updated", out_of_window, 1'b0);

      // R5: exact qualification length after a fault
      sample(12'd10);
      for (int i = 0; i < QUAL - 1; i++) sample(12'd2100);
      chk("R5 not yet locked", locked, 1'b0);
      sample(12'd2100);
      chk("R5 locked on last sample", locked, 1'b1);
      repeat (8) @(negedge clk);
      chk("R5 lock held", locked, 1'b1);

      // R4: one bad sample drops lock and restarts the count
      sample(12'd4090);
      chk("R4 drop", locked, 1'b0);
      for (int i = 0; i < QUAL - 1; i++) sample(12'd1500);
      chk("R4 count restarted", locked, 1'b0);
      sample(12'd1500);
      chk("R4 relock", locked, 1'b1);

      // R7, R8: dead reference
      ref_en = 1'b0;
      repeat (LIMIT + 20) @(negedge clk);
      chk("R7 ref_missing set", ref_missing, 1'b1);
      chk("R7 osc_missing clear", osc_missing, 1'b0);
      chk("R8 unlocked on ref loss", locked, 1'b0);
      for (int i = 0; i < QUAL + 2; i++) sample(12'd2048);
      chk("R8 mid-scale no lock", locked, 1'b0);
      ref_en = 1'b1;
      repeat (20) @(negedge clk);
      chk("R6 ref recovered", ref_missing, 1'b0);

      // R7: dead oscillator
      osc_en = 1'b0;
      repeat (LIMIT + 20) @(negedge clk);
      chk("R7 osc_missing set", osc_missing, 1'b1);
      chk("R7 ref_missing clear", ref_missing, 1'b0);
      chk("R8 unlocked on osc loss", locked, 1'b0);
      osc_en = 1'b1;
      repeat (20) @(negedge clk);
      chk("R6 osc recovered", osc_missing, 1'b0);

      // R9: reset while locked
      for (int i = 0; i < QUAL; i++) sample(12'd2048);
      chk("R5 locked before reset", locked, 1'b1);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R9 reset unlocks", locked, 1'b0);
      chk("R9 reset sets ref_missing", ref_missing, 1'b1);
      rst = 1'b0;

      done = 1'b1;
      summary();
      $finish;
   end
endmodule